// File: doc/BRIEF.md
# Prioritized Interrupt Controller Register Block

This block gathers 32 level-sensitive interrupt lines and tracks three bits of state for each line: enabled, pending and active. Software reaches it through a plain word-addressed register port with address, write data, a write strobe and combinational read data. Enables and pending bits change only through paired set and clear words. Writing a 1 acts on that line and writing a 0 leaves it alone. Each line also has a two-bit priority, and four priorities are packed into each 32-bit word.

On every cycle the block picks the best candidate among the lines that are pending, enabled and not active. It raises a request to the processor when that candidate may preempt the interrupt now running. Along with the request it gives the interrupt number and the word address of its handler entry in a vector table based at zero. An acknowledge moves the chosen line from pending to active. A return pulse retires the most recently activated line, which is held on a small stack ordered by priority.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Word 0 (enable-set) ORs the written ones into the enable vector. Word 1 (enable-clear) clears the enable bits written as one. Reading either word returns the enable vector, and zero bits in a write change nothing.
- R2: Word 2 (pending-set) and word 3 (pending-clear) act on the pending vector with the same write-one policy, and reading either returns the pending vector. Word 4 reads the active vector.
- R3: A line whose input is high while it is disabled becomes pending, and it is never requested or made active while it is disabled.
- R4: The priority of line n is held in word 8+n/4, in byte n%4, in bits [8*(n%4)+7 : 8*(n%4)+6]. The lower six bits of each byte are ignored on write and read as zero.
- R5: The selected line is the candidate (pending, enabled, not active) with the lowest numeric priority. Ties go to the lowest line number.
- R6: A request is raised only if nothing is active, or if the selected priority is strictly lower in value than that of the most recent active line. At most one line per priority level can be active.
- R7: An acknowledge while a request is raised clears the selected line's pending bit and sets its active bit at the same edge. An acknowledge with no request has no effect.
- R8: A return pulse clears the active bit of the most recently activated line, and a pulse with nothing active does nothing. When return and acknowledge arrive together, the acknowledge is ignored.
- R9: An active line stays active through enable-clear and pending-clear writes until a return retires it.
- R10: A line held high while it is not active sets its pending bit again every cycle, except in the cycle it is acknowledged. A rising input on an active line sets pending so the line re-enters after its return.
- R11: When an input is high in the same cycle as a pending-clear write to that line, the pending bit stays set.
- R12: While requesting, the interrupt number output is the line number and the vector output is 16 plus the line number. Both read zero when there is no request.
- R13: Reset clears the enable, pending, active and priority state, and all writes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_in | input | 32 | Level-sensitive interrupt lines |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_id | output | 5 | Number of the requested line |
| irq_vec | output | 8 | Vector table word address of the requested line |
| irq_ack | input | 1 | Processor accepts the presented interrupt |
| exc_ret | input | 1 | Processor returns from the current handler |

## Verification
The assertions assume that irq_ack and exc_ret are single-cycle pulses from a processor that follows the request. They also assume that no input rises on the same line in the cycle it is acknowledged. The bench drives every input at the falling edge and pulses an acknowledge only after it has seen a request. It releases or holds interrupt lines in cycles apart from the acknowledges. The one exception is the directed case that deliberately sends an acknowledge and a return together while nothing is active.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    // Geometry of the controller
    localparam int PIC_IRQS   = 32;
    localparam int PIC_PRIO_W = 2;
    localparam int PIC_ID_W   = $clog2(PIC_IRQS);
    localparam int PIC_LEVELS = 1 << PIC_PRIO_W;
    localparam int PIC_DW     = 32;
    localparam int PIC_PER_WD = PIC_DW / 8;
    localparam int PIC_PRIO_WORDS = PIC_IRQS / PIC_PER_WD;

    // Word addresses of the register port
    localparam int ADR_EN_SET   = 0;
    localparam int ADR_EN_CLR   = 1;
    localparam int ADR_PEND_SET = 2;
    localparam int ADR_PEND_CLR = 3;
    localparam int ADR_ACTIVE   = 4;
    localparam int ADR_PRIO     = 8;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_EN_SET,
        OP_EN_CLR,
        OP_PEND_SET,
        OP_PEND_CLR,
        OP_PRIO
    } bus_op_e;

    // A line and its priority, used for the pick result and stack entries
    typedef struct packed {
        logic                  valid;
        logic [PIC_ID_W-1:0]   id;
        logic [PIC_PRIO_W-1:0] prio;
    } irq_ref_t;

    function automatic logic [PIC_IRQS-1:0] line_mask(input logic [PIC_ID_W-1:0] id);
        logic [PIC_IRQS-1:0] m;
        m = '0;
        m[id] = 1'b1;
        return m;
    endfunction

    function automatic logic [7:0] prio_byte(input logic [PIC_PRIO_W-1:0] p);
        return {p, {(8 - PIC_PRIO_W){1'b0}}};
    endfunction

endpackage

// File: rtl/pic_pick.sv
module pic_pick
    import prio_irq_pkg::*;
(
    input  logic [PIC_IRQS-1:0]                 cand,
    input  logic [PIC_IRQS-1:0][PIC_PRIO_W-1:0] prio,
    output irq_ref_t                            best
);
    // Linear scan: strict compare keeps the lowest index on equal priority
    always_comb begin
        best = '0;
        for (int i = 0; i < PIC_IRQS; i++) begin
            if (cand[i] && (!best.valid || prio[i] < best.prio)) begin
                best.valid = 1'b1;
                best.id    = PIC_ID_W'(i);
                best.prio  = prio[i];
            end
        end
    end
endmodule

// File: rtl/pic_act_stack.sv
module pic_act_stack
    import prio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  irq_ref_t push_ref,
    input  logic     pop,
    output irq_ref_t top
);
    localparam int DEPTH = PIC_LEVELS;
    localparam int CNT_W = $clog2(DEPTH + 1);

    irq_ref_t           ent_q [DEPTH];
    logic [CNT_W-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else if (pop && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            ent_q[cnt_q - 1'b1] <= '0;
        end else if (push && cnt_q != CNT_W'(DEPTH)) begin
            ent_q[cnt_q[CNT_W-1:0]] <= push_ref;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt_q == CNT_W'(i + 1)) top = ent_q[i];
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [PIC_DW-1:0]    bus_wdata,
    input  logic                 bus_we,
    output logic [PIC_DW-1:0]    bus_rdata,
    input  logic [PIC_IRQS-1:0]  irq_in,
    output logic                 irq_req,
    output logic [PIC_ID_W-1:0]  irq_id,
    output logic [VEC_W-1:0]     irq_vec,
    input  logic                 irq_ack,
    input  logic                 exc_ret
);
    localparam logic [ADDR_W-1:0] A_EN_SET   = ADDR_W'(ADR_EN_SET);
    localparam logic [ADDR_W-1:0] A_EN_CLR   = ADDR_W'(ADR_EN_CLR);
    localparam logic [ADDR_W-1:0] A_PEND_SET = ADDR_W'(ADR_PEND_SET);
    localparam logic [ADDR_W-1:0] A_PEND_CLR = ADDR_W'(ADR_PEND_CLR);
    localparam logic [ADDR_W-1:0] A_ACTIVE   = ADDR_W'(ADR_ACTIVE);

    logic [PIC_IRQS-1:0]                 en_q, pend_q, act_q, lvl_q;
    logic [PIC_IRQS-1:0][PIC_PRIO_W-1:0] prio_q;
    logic [PIC_PRIO_WORDS-1:0][PIC_DW-1:0] prio_words;

    bus_op_e  op;
    irq_ref_t sel, stk_top;
    logic     do_ack, do_ret;
    logic [PIC_IRQS-1:0] ack_vec, ret_vec, wmask, hw_set;

    // ---------------- write decode ----------------
    always_comb begin
        op = OP_NONE;
        if (bus_we) begin
            unique case (bus_addr)
                A_EN_SET:   op = OP_EN_SET;
                A_EN_CLR:   op = OP_EN_CLR;
                A_PEND_SET: op = OP_PEND_SET;
                A_PEND_CLR: op = OP_PEND_CLR;
                default:    op = OP_PRIO;
            endcase
        end
    end
    assign wmask = bus_wdata[PIC_IRQS-1:0];

    // ---------------- selection ----------------
    pic_pick pick_i (
        .cand (pend_q & en_q & ~act_q),
        .prio (prio_q),
        .best (sel)
    );

    pic_act_stack stack_i (
        .clk      (clk),
        .rst      (rst),
        .push     (do_ack),
        .push_ref (sel),
        .pop      (do_ret),
        .top      (stk_top)
    );

    assign irq_req = sel.valid && (!stk_top.valid || sel.prio < stk_top.prio);
    assign irq_id  = irq_req ? sel.id : '0;
    assign irq_vec = irq_req ? (VEC_W'(VEC_BASE) + VEC_W'(sel.id)) : '0;

    assign do_ret  = exc_ret && stk_top.valid;
    assign do_ack  = irq_ack && irq_req && !exc_ret;
    assign ack_vec = do_ack ? line_mask(sel.id) : '0;
    assign ret_vec = do_ret ? line_mask(stk_top.id) : '0;

    // Held level re-pends while not active; a fresh rise always pends
    assign hw_set = (irq_in & ~act_q & ~ack_vec) | (irq_in & ~lvl_q);

    // ---------------- state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
            act_q  <= '0;
            lvl_q  <= '0;
        end else begin
            lvl_q <= irq_in;
            unique case (op)
                OP_EN_SET: en_q <= en_q | wmask;
                OP_EN_CLR: en_q <= en_q & ~wmask;
                default:   en_q <= en_q;
            endcase
            unique case (op)
                OP_PEND_SET: pend_q <= ((pend_q | wmask) & ~ack_vec) | hw_set;
                OP_PEND_CLR: pend_q <= (pend_q & ~wmask & ~ack_vec) | hw_set;
                default:     pend_q <= (pend_q & ~ack_vec) | hw_set;
            endcase
            act_q <= (act_q | ack_vec) & ~ret_vec;
        end
    end

    // Priority fields: one writer per line, placed by its word and byte
    for (genvar g = 0; g < PIC_IRQS; g++) begin : g_prio
        localparam int WORD = g / PIC_PER_WD;
        localparam int BYTE = g % PIC_PER_WD;
        localparam logic [ADDR_W-1:0] A_WORD = ADDR_W'(ADR_PRIO + WORD);
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[g] <= '0;
            else if (op == OP_PRIO && bus_addr == A_WORD)
                prio_q[g] <= bus_wdata[8*BYTE+7 -: PIC_PRIO_W];
        end
        assign prio_words[WORD][8*BYTE +: 8] = prio_byte(prio_q[g]);
    end

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_EN_SET, A_EN_CLR:     bus_rdata = PIC_DW'(en_q);
            A_PEND_SET, A_PEND_CLR: bus_rdata = PIC_DW'(pend_q);
            A_ACTIVE:               bus_rdata = PIC_DW'(act_q);
            default: begin
                for (int r = 0; r < PIC_PRIO_WORDS; r++) begin
                    if (bus_addr == ADDR_W'(ADR_PRIO + r)) bus_rdata = prio_words[r];
                end
            end
        endcase
    end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
    import prio_irq_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                irq_req,
    input logic [PIC_ID_W-1:0] irq_id,
    input logic [VEC_W-1:0]    irq_vec,
    input logic                irq_ack,
    input logic                exc_ret,
    input logic [PIC_IRQS-1:0] en_q,
    input logic [PIC_IRQS-1:0] pend_q,
    input logic [PIC_IRQS-1:0] act_q
);
    // R3
    req_legal_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (en_q[irq_id] && pend_q[irq_id] && !act_q[irq_id]));

    // R6
    active_bound_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(act_q) <= PIC_LEVELS);

    // R7
    ack_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req && !exc_ret) |=> act_q[$past(irq_id)]);

    // R8
    ret_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_ret && act_q != '0) |=> ($countones(act_q) + 1 == $countones($past(act_q))));

    // R9
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !exc_ret |=> ((act_q & $past(act_q)) == $past(act_q)));

    // R12
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_req |-> (irq_id == '0 && irq_vec == '0));

    // R13
    rst_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (en_q == '0 && pend_q == '0 && act_q == '0));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.VEC_W(VEC_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .irq_req (irq_req),
    .irq_id  (irq_id),
    .irq_vec (irq_vec),
    .irq_ack (irq_ack),
    .exc_ret (exc_ret),
    .en_q    (en_q),
    .pend_q  (pend_q),
    .act_q   (act_q)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic        irq_req;
    logic [4:0]  irq_id;
    logic [7:0]  irq_vec;
    logic        irq_ack = 1'b0;
    logic        exc_ret = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [3:0] W_ESET = 4'd0, W_ECLR = 4'd1, W_PSET = 4'd2,
                           W_PCLR = 4'd3, W_ACT = 4'd4, W_PRIO = 4'd8;

    always #5 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .irq_req(irq_req), .irq_id(irq_id), .irq_vec(irq_vec),
        .irq_ack(irq_ack), .exc_ret(exc_ret)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic out_chk(input string tag, input logic req, input logic [4:0] id, input logic [7:0] vec);
        check({tag, " req"}, 32'(irq_req), 32'(req));
        check({tag, " id"},  32'(irq_id),  32'(id));
        check({tag, " vec"}, 32'(irq_vec), 32'(vec));
    endtask

    task automatic ack();
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic ret();
        exc_ret = 1'b1; @(negedge clk); exc_ret = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R13 enable", W_ESET, 0);
        rd_chk("R13 pending", W_PSET, 0);
        rd_chk("R13 active", W_ACT, 0);
        rd_chk("R13 prio", W_PRIO, 0);
        out_chk("R12 idle", 0, 0, 0);
    endtask

    task automatic t_enable();
        wr(W_ESET, 32'h0000_00F0);
        wr(W_ESET, 32'h0000_0003);
        rd_chk("R1 set read", W_ESET, 32'h0000_00F3);
        rd_chk("R1 clr-word read", W_ECLR, 32'h0000_00F3);
        wr(W_ECLR, 32'h0000_0011);
        rd_chk("R1 clear", W_ESET, 32'h0000_00E2);
        wr(W_ECLR, 32'hFFFF_FFFF);
        rd_chk("R1 all clear", W_ECLR, 0);
    endtask

    task automatic t_pending();
        wr(W_PSET, 32'h8000_0001);
        wr(W_PCLR, 32'h0000_0001);
        rd_chk("R2 pend read", W_PSET, 32'h8000_0000);
        rd_chk("R2 pend clr-word read", W_PCLR, 32'h8000_0000);
        wr(W_PCLR, 32'hFFFF_FFFF);
        rd_chk("R2 pend clear", W_PSET, 0);
    endtask

    task automatic t_prio();
        wr(W_PRIO + 4'd1, 32'hFFC0_4001);
        rd_chk("R4 packing", W_PRIO + 4'd1, 32'hC0C0_4000);
        rd_chk("R4 other word", W_PRIO, 0);
        wr(W_PRIO + 4'd1, 0);
    endtask

    task automatic t_disabled();
        irq_in[5] = 1'b1;
        @(negedge clk);
        irq_in[5] = 1'b0;
        rd_chk("R3 pend while disabled", W_PSET, 32'h0000_0020);
        out_chk("R3 no request", 0, 0, 0);
        ack();
        rd_chk("R7 ack without request", W_ACT, 0);
        rd_chk("R7 pend kept", W_PSET, 32'h0000_0020);
        wr(W_PCLR, 32'h0000_0020);
    endtask

    task automatic t_select();
        wr(W_PRIO + 4'd0, 32'h8000_0000);  // line 3 -> 2
        wr(W_PRIO + 4'd2, 32'h0000_4000);  // line 9 -> 1
        wr(W_PRIO + 4'd3, 32'h0000_0040);  // line 12 -> 1
        wr(W_ESET, 32'h0000_1208);
        wr(W_PSET, 32'h0000_1208);
        out_chk("R5 best prio low id", 1, 9, 25);
        ack();
        rd_chk("R7 active set", W_ACT, 32'h0000_0200);
        rd_chk("R7 pend cleared", W_PSET, 32'h0000_1008);
        out_chk("R6 equal prio blocked", 0, 0, 0);
        wr(W_ESET, 32'h0000_0001);
        wr(W_PSET, 32'h0000_0001);
        out_chk("R6 preempt", 1, 0, 16);
        ack();
        rd_chk("R6 nested active", W_ACT, 32'h0000_0201);
        ret();
        rd_chk("R8 pop most recent", W_ACT, 32'h0000_0200);
        ret();
        rd_chk("R8 second pop", W_ACT, 0);
        out_chk("R5 next candidate", 1, 12, 28);
        ack(); ret();
        out_chk("R5 last candidate", 1, 3, 19);
        ack(); ret();
        out_chk("R12 drained", 0, 0, 0);
        wr(W_ECLR, 32'hFFFF_FFFF);
        wr(W_PRIO + 4'd0, 0);
        wr(W_PRIO + 4'd2, 0);
        wr(W_PRIO + 4'd3, 0);
    endtask

    task automatic t_survive();
        wr(W_ESET, 32'h0000_0080);
        wr(W_PSET, 32'h0000_0080);
        out_chk("R9 request", 1, 7, 23);
        ack();
        wr(W_ECLR, 32'h0000_0080);
        wr(W_PCLR, 32'h0000_0080);
        rd_chk("R9 active survives", W_ACT, 32'h0000_0080);
        ret();
        rd_chk("R9 retired", W_ACT, 0);
        wr(W_ESET, 32'h0000_0100);
        wr(W_PSET, 32'h0000_0100);
        irq_ack = 1'b1; exc_ret = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0; exc_ret = 1'b0;
        rd_chk("R8 ack ignored with return", W_ACT, 0);
        rd_chk("R8 pend kept", W_PSET, 32'h0000_0100);
        wr(W_PCLR, 32'h0000_0100);
        wr(W_ECLR, 32'hFFFF_FFFF);
    endtask

    task automatic t_level();
        wr(W_ESET, 32'h0000_0004);
        irq_in[2] = 1'b1;
        @(negedge clk);
        out_chk("R10 level request", 1, 2, 18);
        ack();
        @(negedge clk);
        rd_chk("R10 held no re-pend", W_PSET, 0);
        rd_chk("R10 active", W_ACT, 32'h0000_0004);
        irq_in[2] = 1'b0;
        @(negedge clk);
        irq_in[2] = 1'b1;
        @(negedge clk);
        rd_chk("R10 rise while active", W_PSET, 32'h0000_0004);
        ret();
        out_chk("R10 re-entry", 1, 2, 18);
        irq_in[2] = 1'b0;
        ack();
        ret();
        rd_chk("R10 line low", W_PSET, 0);
        wr(W_ECLR, 32'hFFFF_FFFF);
    endtask

    task automatic t_race();
        irq_in[4] = 1'b1;
        wr(W_PCLR, 32'h0000_0010);
        rd_chk("R11 assertion wins", W_PSET, 32'h0000_0010);
        irq_in[4] = 1'b0;
        @(negedge clk);
        wr(W_PCLR, 32'h0000_0010);
        rd_chk("R11 clear after drop", W_PSET, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_enable();
        t_pending();
        t_prio();
        t_disabled();
        t_select();
        t_survive();
        t_level();
        t_race();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule